// File: doc/BRIEF.md
# IDE Programmed-I/O and Multiword DMA Strobe Sequencer

This block is the host side of a parallel IDE channel. The host hands it one transfer at a time. A transfer names either a task-file register, given as a register-block select and a 3-bit address, or a DMA word. It also carries a direction and, for writes, a 16-bit data word. The sequencer presents the register select or the DMA acknowledge to the drive. It then pulses the read or write strobe, holds the strobe low for as long as the drive pulls its ready line low, and returns the captured read word to the host.

Three counts of clock cycles set the timing: the address setup before the strobe, the minimum strobe-low time and the recovery time with the strobe high. A count of zero acts as one cycle. One strobe path serves register-addressed transfers and DMA-acknowledged transfers alike. A DMA transfer starts only while the drive requests one. The drive's ready and DMA request lines are asynchronous, and each passes through a two-flop synchroniser before the control logic uses it.

Top module: `ide_strobe_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, both chip selects, the DMA acknowledge and both strobes are high (inactive), the write-data enable is low, and `busy` and `rsp_valid` are low.
- R2: A register transfer is accepted from idle when `req_valid` is high. In the first cycle after the accepting edge, `busy` goes high. `req_sel`=0 drives `dev_cs0_n` low and `req_sel`=1 drives `dev_cs1_n` low, with `dev_addr` equal to `req_addr`. Both strobes stay high for max(`cfg_setup`,1) cycles.
- R3: After setup, exactly one strobe goes low: `dev_dior_n` for a read (`req_write`=0) or `dev_diow_n` for a write (`req_write`=1). It stays low for at least max(`cfg_active`,1) cycles, and for exactly that many cycles when ready is high throughout.
- R4: For a read, the value on `dev_din` at the clock edge where the strobe rises appears on `rsp_rdata`. `rsp_valid` is high for exactly one cycle, the first cycle with the strobe high again, for both reads and writes.
- R5: For a write, `dev_dout` equals `req_wdata` and `dev_dout_oe` is high from the first setup cycle through the last recovery cycle, which includes the cycle in which the write strobe rises.
- R6: If `dev_iordy` is low when the minimum strobe time ends, the strobe stays low. After `dev_iordy` returns high, the strobe rises on the third clock edge, because two synchroniser flops and the sequencer register lie in the path.
- R7: A low pulse on `dev_iordy` that has cleared the synchroniser before the minimum strobe time ends does not lengthen the strobe.
- R8: After the strobe rises, the strobe stays high, the selects stay as they were and `busy` stays high for max(`cfg_recover`,1) cycles. Then everything returns to the R1 idle levels.
- R9: A DMA transfer (`req_dma`=1) drives `dev_dack_n` low from the first setup cycle through the last recovery cycle. Both chip selects stay high throughout, and the strobe timing follows R2, R3, R6 and R8.
- R10: A DMA request is not accepted while the synchronised `dev_dmarq` is low, and the outputs stay idle. Once `dev_dmarq` rises with the request still held, `busy` rises on the third clock edge.
- R11: A `req_valid` presented while `busy` is high has no effect on the outputs of the transfer in flight and starts no further transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Host transfer request |
| req_dma | input | 1 | 1 = DMA-acknowledged transfer, 0 = register transfer |
| req_write | input | 1 | 1 = write to drive, 0 = read from drive |
| req_sel | input | 1 | Register block: 0 = command block select, 1 = control block select |
| req_addr | input | 3 | Register address within the block |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transfer in progress; requests are ignored while high |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data captured at the strobe rising edge |
| cfg_setup | input | CNT_W | Setup cycles before the strobe |
| cfg_active | input | CNT_W | Minimum strobe-low cycles |
| cfg_recover | input | CNT_W | Recovery cycles after the strobe |
| dev_cs0_n | output | 1 | Command block chip select, active low |
| dev_cs1_n | output | 1 | Control block chip select, active low |
| dev_addr | output | 3 | Register address lines |
| dev_dack_n | output | 1 | DMA acknowledge, active low |
| dev_dior_n | output | 1 | Read strobe, active low |
| dev_diow_n | output | 1 | Write strobe, active low |
| dev_dout | output | 16 | Data toward the drive |
| dev_dout_oe | output | 1 | Drive enable for `dev_dout` |
| dev_din | input | 16 | Data from the drive |
| dev_iordy | input | 1 | Drive ready (asynchronous) |
| dev_dmarq | input | 1 | Drive DMA request (asynchronous) |

## Verification
Two things can fall on the same clock edge: the end of the minimum strobe count and the arrival of the synchronised ready. The bench holds `dev_iordy` low from before the request and releases it once a chosen number of strobe-low cycles have been seen. It then checks that the strobe width equals the minimum plus the stall plus the two-flop latency. In a separate run it drops ready for one cycle early in the strobe and checks that the width stays at the minimum. Read capture shares the exit edge as well. The drive data changes to its correct value only once the strobe is low and changes again right after the strobe rises, so the returned word shows which edge captured it.

// File: rtl/ide_seq_pkg.sv
package ide_seq_pkg;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACTIVE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_t;

  typedef struct packed {
    logic              dma;
    logic              write;
    logic              sel;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } xfer_t;

endpackage

// File: rtl/ide_sync2.sv
module ide_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] hold_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[b] <= 1'b0;
        hold_q[b] <= 1'b0;
      end else begin
        meta_q[b] <= async_i[b];
        hold_q[b] <= meta_q[b];
      end
    end
  end

  assign sync_o = hold_q;

endmodule

// File: rtl/ide_phase_timer.sv
module ide_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (load_val == '0) ? '0 : load_val - 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/ide_strobe_seq.sv
module ide_strobe_seq
  import ide_seq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_dma,
  input  logic              req_write,
  input  logic              req_sel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_active,
  input  logic [CNT_W-1:0]  cfg_recover,
  output logic              dev_cs0_n,
  output logic              dev_cs1_n,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dev_dack_n,
  output logic              dev_dior_n,
  output logic              dev_diow_n,
  output logic [DATA_W-1:0] dev_dout,
  output logic              dev_dout_oe,
  input  logic [DATA_W-1:0] dev_din,
  input  logic              dev_iordy,
  input  logic              dev_dmarq
);

  localparam int SYNC_W = 2;

  phase_t            ph_q, ph_d;
  xfer_t             xf_q;
  logic [DATA_W-1:0] rd_q;
  logic              rsp_q;
  logic [SYNC_W-1:0] sync_w;
  logic              rdy_s, drq_s;
  logic              accept, capture;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              act, pio;

  ide_sync2 #(.WIDTH(SYNC_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({dev_dmarq, dev_iordy}),
    .sync_o  (sync_w)
  );
  assign rdy_s = sync_w[0];
  assign drq_s = sync_w[1];

  ide_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (act),
    .done     (tmr_done)
  );

  // next-state logic
  always_comb begin
    ph_d     = ph_q;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = cfg_setup;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_valid && (!req_dma || drq_s)) begin
          ph_d     = PH_SETUP;
          accept   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = cfg_setup;
        end
      end
      PH_SETUP: begin
        if (tmr_done) begin
          ph_d     = PH_ACTIVE;
          tmr_load = 1'b1;
          tmr_val  = cfg_active;
        end
      end
      PH_ACTIVE: begin
        if (tmr_done && rdy_s) begin
          ph_d     = PH_RECOVER;
          capture  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = cfg_recover;
        end
      end
      PH_RECOVER: begin
        if (tmr_done) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      xf_q  <= '0;
      rd_q  <= '0;
      rsp_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      rsp_q <= capture;
      if (accept)  xf_q <= '{dma: req_dma, write: req_write, sel: req_sel,
                             addr: req_addr, wdata: req_wdata};
      if (capture) rd_q <= dev_din;
    end
  end

  // output decode from registered state
  assign act         = (ph_q != PH_IDLE);
  assign pio         = act && !xf_q.dma;
  assign busy        = act;
  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rd_q;
  assign dev_cs0_n   = !(pio && !xf_q.sel);
  assign dev_cs1_n   = !(pio &&  xf_q.sel);
  assign dev_addr    = pio ? xf_q.addr : '0;
  assign dev_dack_n  = !(act && xf_q.dma);
  assign dev_dior_n  = !((ph_q == PH_ACTIVE) && !xf_q.write);
  assign dev_diow_n  = !((ph_q == PH_ACTIVE) &&  xf_q.write);
  assign dev_dout    = xf_q.wdata;
  assign dev_dout_oe = act && xf_q.write;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dev_dior_n && !dev_diow_n)); // R3
  AST_MIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dev_dior_n) || $rose(dev_diow_n)) |-> $past(tmr_done)); // R3
  AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dev_dior_n) || $rose(dev_diow_n)) |-> $past(rdy_s)); // R6
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_diow_n) |-> (dev_dout_oe && $stable(dev_dout))); // R5
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_dior_n || !dev_diow_n) |-> ((!dev_dack_n) ^ (!dev_cs0_n || !dev_cs1_n))); // R9
  AST_DACK_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_dack_n) |-> $past(drq_s)); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4

endmodule

// File: tb/ide_strobe_seq_test.sv
`timescale 1ns/1ps
module ide_strobe_seq_test;

  localparam int CW = 6;

  typedef struct packed {
    logic        dma;
    logic        wr;
    logic        sel;
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [5:0]  s;
    logic [5:0]  a;
    logic [5:0]  r;
    logic [3:0]  stall;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 3'd7, 16'h0000, 16'hA5C3, 6'd2, 6'd3, 6'd2, 4'd0},
    '{1'b0, 1'b1, 1'b1, 3'd6, 16'h1234, 16'h0000, 6'd1, 6'd4, 6'd1, 4'd0},
    '{1'b0, 1'b0, 1'b0, 3'd0, 16'h0000, 16'h0F0F, 6'd0, 6'd0, 6'd0, 4'd0},
    '{1'b0, 1'b0, 1'b1, 3'd5, 16'h0000, 16'hBEEF, 6'd1, 6'd2, 6'd3, 4'd3},
    '{1'b1, 1'b1, 1'b0, 3'd0, 16'hCAFE, 16'h0000, 6'd2, 6'd2, 6'd2, 4'd2},
    '{1'b1, 1'b0, 1'b0, 3'd0, 16'h0000, 16'h8001, 6'd1, 6'd5, 6'd1, 4'd0},
    '{1'b0, 1'b1, 1'b1, 3'd2, 16'h5A5A, 16'h0000, 6'd3, 6'd1, 6'd1, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_dma, req_write, req_sel;
  logic [2:0] req_addr;
  logic [15:0] req_wdata;
  logic busy, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [CW-1:0] cfg_setup, cfg_active, cfg_recover;
  logic dev_cs0_n, dev_cs1_n, dev_dack_n, dev_dior_n, dev_diow_n, dev_dout_oe;
  logic [2:0] dev_addr;
  logic [15:0] dev_dout, dev_din;
  logic dev_iordy, dev_dmarq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ide_strobe_seq #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_dma(req_dma), .req_write(req_write),
    .req_sel(req_sel), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_setup(cfg_setup), .cfg_active(cfg_active), .cfg_recover(cfg_recover),
    .dev_cs0_n(dev_cs0_n), .dev_cs1_n(dev_cs1_n), .dev_addr(dev_addr),
    .dev_dack_n(dev_dack_n), .dev_dior_n(dev_dior_n), .dev_diow_n(dev_diow_n),
    .dev_dout(dev_dout), .dev_dout_oe(dev_dout_oe), .dev_din(dev_din),
    .dev_iordy(dev_iordy), .dev_dmarq(dev_dmarq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int atl1(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic bit idle_pins();
    return dev_cs0_n && dev_cs1_n && dev_dack_n && dev_dior_n && dev_diow_n
           && !dev_dout_oe && !busy && !rsp_valid;
  endfunction

  // selects and write data expected while the transfer is in flight
  function automatic bit sel_ok(input vec_t v);
    bit ok;
    if (v.dma) ok = !dev_dack_n && dev_cs0_n && dev_cs1_n;
    else ok = dev_dack_n && (dev_cs0_n == v.sel) && (dev_cs1_n == !v.sel)
              && (dev_addr == v.addr);
    if (v.wr) ok = ok && dev_dout_oe && (dev_dout == v.wdata);
    else      ok = ok && !dev_dout_oe;
    return ok;
  endfunction

  // glitch: one-cycle ready drop at the first strobe cycle; poke: request while busy
  task automatic xfer(input vec_t v, input bit glitch, input bit poke);
    int ns, na, nr, g, exp_a;
    bit sok;
    ns = 0; na = 0; nr = 0; g = 0; sok = 1'b1;
    cfg_setup = v.s; cfg_active = v.a; cfg_recover = v.r;
    req_dma = v.dma; req_write = v.wr; req_sel = v.sel;
    req_addr = v.addr; req_wdata = v.wdata;
    dev_iordy = (v.stall == 0);
    dev_din = 16'hDEAD;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R2 busy after accept", busy, 1);
    while (dev_dior_n && dev_diow_n && busy && g < 200) begin
      sok = sok && sel_ok(v);
      ns++; g++;
      @(negedge clk);
    end
    chk(ns == atl1(v.s), "R2 setup cycles", ns, atl1(v.s));
    dev_din = v.rdata;
    while ((!dev_dior_n || !dev_diow_n) && g < 200) begin
      sok = sok && sel_ok(v);
      if (v.wr) sok = sok && !dev_diow_n && dev_dior_n;
      else      sok = sok && !dev_dior_n && dev_diow_n;
      na++; g++;
      if (poke && na == 1) begin
        req_valid = 1'b1; req_addr = ~v.addr; req_sel = ~v.sel;
      end
      if (glitch && na == 1) dev_iordy = 1'b0;
      if (glitch && na == 2) dev_iordy = 1'b1;
      if (v.stall != 0 && na == atl1(v.a) + int'(v.stall)) dev_iordy = 1'b1;
      @(negedge clk);
    end
    exp_a = atl1(v.a) + ((v.stall != 0) ? int'(v.stall) + 2 : 0);
    if (v.stall != 0) chk(na == exp_a, "R6 stretched strobe cycles", na, exp_a);
    else if (glitch)  chk(na == exp_a, "R7 early ready drop ignored", na, exp_a);
    else              chk(na == exp_a, "R3 strobe cycles", na, exp_a);
    chk(rsp_valid, "R4 completion pulse", rsp_valid, 1);
    if (!v.wr) chk(rsp_rdata == v.rdata, "R4 read capture at strobe rise", rsp_rdata, v.rdata);
    dev_din = ~v.rdata;
    req_valid = 1'b0;
    while (busy && g < 200) begin
      sok = sok && sel_ok(v) && dev_dior_n && dev_diow_n;
      nr++; g++;
      @(negedge clk);
    end
    chk(nr == atl1(v.r), "R8 recovery cycles", nr, atl1(v.r));
    if (v.dma)      chk(sok, "R9 dack held, selects idle", sok, 1);
    else if (poke)  chk(sok, "R11 in-flight outputs unchanged", sok, 1);
    else if (v.wr)  chk(sok, "R5 write data held through strobe", sok, 1);
    else            chk(sok, "R2 selects and address held", sok, 1);
    chk(idle_pins(), "R8 idle after recovery", idle_pins(), 1);
    if (!v.wr) chk(rsp_rdata == v.rdata, "R4 read data held", rsp_rdata, v.rdata);
    @(negedge clk);
    if (poke) chk(!busy, "R11 no second transfer", busy, 0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    vec_t d;
    int g;
    rst_n = 1'b0;
    req_valid = 1'b0; req_dma = 1'b0; req_write = 1'b0; req_sel = 1'b0;
    req_addr = '0; req_wdata = '0;
    cfg_setup = '0; cfg_active = '0; cfg_recover = '0;
    dev_din = '0; dev_iordy = 1'b1; dev_dmarq = 1'b1;
    repeat (3) @(negedge clk);
    chk(idle_pins(), "R1 idle during reset", idle_pins(), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(idle_pins(), "R1 idle after reset", idle_pins(), 1);

    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i], 1'b0, 1'b0);
      @(negedge clk);
    end

    // R7: ready drop that clears before the minimum width ends
    d = '{1'b0, 1'b0, 1'b0, 3'd3, 16'h0000, 16'h3C3C, 6'd1, 6'd6, 6'd1, 4'd0};
    xfer(d, 1'b1, 1'b0);
    @(negedge clk);

    // R11: request presented mid-transfer
    d = '{1'b0, 1'b0, 1'b0, 3'd4, 16'h0000, 16'h7E7E, 6'd1, 6'd3, 6'd2, 4'd0};
    xfer(d, 1'b0, 1'b1);
    @(negedge clk);

    // R10: DMA request held off until the drive requests
    dev_dmarq = 1'b0;
    repeat (3) @(negedge clk);
    cfg_setup = 6'd1; cfg_active = 6'd2; cfg_recover = 6'd1;
    req_dma = 1'b1; req_write = 1'b0; dev_iordy = 1'b1;
    req_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && dev_dack_n, "R10 no start without dma request", busy, 0);
    dev_dmarq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!busy, "R10 still idle during sync", busy, 0);
    @(negedge clk);
    chk(busy && !dev_dack_n, "R10 start after dma request", busy, 1);
    req_valid = 1'b0;
    g = 0;
    while (busy && g < 100) begin g++; @(negedge clk); end
    chk(idle_pins(), "R10 dma transfer completes", idle_pins(), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule